// File: doc/BRIEF.md
# Automatic Crossover Pair-Mapping Controller

This block chooses whether a twisted-pair port maps its transmit and receive pairs straight (MDI) or crossed (MDIX). A downstream pair switch reads the registered select output, and a one-cycle change pulse reports each swap to a status flag elsewhere in the chip. The analog switching, link detection and negotiation sit outside the block. It sees them only through the link input and its select output.

A two-bit mode field either forces one mapping or allows automatic hunting. While hunting, the block holds the current mapping for a pseudo-random interval. If no link has been reported when that interval ends, it switches to the other mapping and draws a new interval. Once link is reported, the mapping stays fixed. If link is later lost, hunting resumes from the held mapping.

Each interval is a value drawn from an 11-bit maximal-length LFSR, multiplied by a parameterized tick prescaler. A short prescaler keeps simulation runs short, and a long one gives real dwell times.

Top module: `xover_sel`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, crossSel is 0 (MDI) and swapPulse is 0. The LFSR is loaded with the SEED parameter, which must be nonzero.
- R2: modeSel 2'b01 forces crossSel to 0, and modeSel 2'b00 forces crossSel to 1 (1 means MDIX). A new modeSel value takes effect at the next clock edge. The interval timer is stopped while a forced mode is selected.
- R3: Automatic operation is selected whenever modeSel[1] is 1. Both 2'b11 (the expected setting) and 2'b10 behave identically.
- R4: The block hunts when modeSel[1]=1, enable=1 and linkUp=0. While hunting, crossSel inverts at each edge where the current interval expires, and the cycle then repeats with a new interval.
- R5: The LFSR advances at every clock edge after reset. Its next state is {s[9:0], s[10]^s[8]}. The first hunting edge starts an interval from the value V that the LFSR holds just before that edge. crossSel then inverts exactly V*TICK_DIV edges later, and a new interval starts at that same edge.
- R6: While linkUp=1 in automatic mode, crossSel does not change.
- R7: When hunting becomes possible again, a new interval starts at the first edge where the conditions of R4 hold. This covers link dropping and enable returning to 1. The interval is drawn per R5 and starts from the currently held crossSel.
- R8: While enable=0 in automatic mode, crossSel does not change.
- R9: swapPulse is 1 for exactly the one cycle that follows each edge at which crossSel changed, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows automatic hunting |
| linkUp | input | 1 | Link established indication |
| modeSel | input | 2 | 00 forced MDIX, 01 forced MDI, 1x automatic |
| crossSel | output | 1 | 0 straight mapping, 1 crossed mapping |
| swapPulse | output | 1 | One-cycle pulse after each change of crossSel |

## Verification
The hardest situation to reach is a swap landing on an exact edge. That edge depends on the LFSR phase at the moment an interval starts, and the phase is set by how many clocks have passed since reset. The bench counts edges from reset release and steps its own copy of the LFSR polynomial. From these it predicts the exact edge of the first swap, the second swap, and the first swap after a link drop. Random segments of mode, enable and link, some of them long, then drive hunting across interrupted and resumed intervals. A cycle-level model built from the requirements checks every cycle of these segments.

// File: rtl/xover_pkg.sv
package xover_pkg;

  localparam int LFSR_W = 11;

  typedef enum logic [1:0] {
    MODE_FORCE_X  = 2'b00,
    MODE_FORCE_S  = 2'b01,
    MODE_AUTO_ALT = 2'b10,
    MODE_AUTO     = 2'b11
  } mode_e;

  // strobes from control to the interval datapath
  typedef struct packed {
    logic clear;  // drop the armed interval
    logic load;   // start a new interval from the LFSR
    logic run;    // let the armed interval count
  } tmrStrobe_t;

  // x^11 + x^9 + 1, maximal length
  function automatic logic [LFSR_W-1:0] lfsrAdvance(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[10] ^ s[8]};
  endfunction

endpackage

// File: rtl/xover_timer.sv
module xover_timer
  import xover_pkg::*;
#(
  parameter int unsigned TICK_DIV = 1024,
  parameter logic [LFSR_W-1:0] SEED = 11'h5A5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  tmrStrobe_t strobe,
  output logic       armed,
  output logic       expire
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [LFSR_W-1:0] lfsr;
  logic [LFSR_W-1:0] dwellCnt;
  logic [PRE_W-1:0]  preCnt;
  logic              preWrap;

  assign preWrap = (preCnt == PRE_LAST);
  assign expire  = armed && preWrap && (dwellCnt == LFSR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr     <= SEED;
      armed    <= 1'b0;
      dwellCnt <= '0;
      preCnt   <= '0;
    end else begin
      lfsr <= lfsrAdvance(lfsr);
      if (strobe.clear) begin
        armed <= 1'b0;
      end else if (strobe.load) begin
        dwellCnt <= lfsr;
        preCnt   <= '0;
        armed    <= 1'b1;
      end else if (strobe.run && armed) begin
        if (preWrap) begin
          preCnt   <= '0;
          dwellCnt <= dwellCnt - LFSR_W'(1);
        end else begin
          preCnt <= preCnt + PRE_W'(1);
        end
      end
    end
  end

  // R5: the generator never locks up in the all-zero state
  p_lfsr_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

  // R5: an armed interval always has time left to count
  p_dwell_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> dwellCnt != '0);

  // R2: a cleared timer cannot report expiry next cycle
  p_clear_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clear |=> !expire);

endmodule

// File: rtl/xover_ctrl.sv
module xover_ctrl
  import xover_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       linkUp,
  input  logic [1:0] modeSel,
  input  logic       armed,
  input  logic       expire,
  output tmrStrobe_t strobe,
  output logic       crossSel,
  output logic       swapPulse
);

  logic autoMode;
  logic hunting;
  logic selNext;

  assign autoMode = modeSel[1];
  assign hunting  = autoMode && enable && !linkUp;

  always_comb begin
    strobe.clear = !hunting;
    strobe.load  = hunting && (!armed || expire);
    strobe.run   = hunting;
  end

  always_comb begin
    selNext = crossSel;
    unique case (modeSel)
      MODE_FORCE_X: selNext = 1'b1;
      MODE_FORCE_S: selNext = 1'b0;
      default:      if (hunting && expire) selNext = !crossSel;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crossSel  <= 1'b0;
      swapPulse <= 1'b0;
    end else begin
      crossSel  <= selNext;
      swapPulse <= (selNext != crossSel);
    end
  end

  p_forced_mdi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (modeSel == MODE_FORCE_S) |=> !crossSel);

  p_forced_mdix_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (modeSel == MODE_FORCE_X) |=> crossSel);

  p_hold_no_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (autoMode && !expire) |=> $stable(crossSel));

  p_link_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (autoMode && linkUp) |=> $stable(crossSel));

  p_enable_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (autoMode && !enable) |=> $stable(crossSel));

  p_pulse_on_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (crossSel != $past(crossSel)) |-> swapPulse);

  p_pulse_only_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    swapPulse |-> (crossSel != $past(crossSel)));

endmodule

// File: rtl/xover_sel.sv
module xover_sel
  import xover_pkg::*;
#(
  parameter int unsigned TICK_DIV = 1024,
  parameter logic [LFSR_W-1:0] SEED = 11'h5A5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       linkUp,
  input  logic [1:0] modeSel,
  output logic       crossSel,
  output logic       swapPulse
);

  tmrStrobe_t strobe;
  logic       armed;
  logic       expire;

  xover_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .linkUp    (linkUp),
    .modeSel   (modeSel),
    .armed     (armed),
    .expire    (expire),
    .strobe    (strobe),
    .crossSel  (crossSel),
    .swapPulse (swapPulse)
  );

  xover_timer #(
    .TICK_DIV (TICK_DIV),
    .SEED     (SEED)
  ) i_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .armed  (armed),
    .expire (expire)
  );

  initial begin
    assert (SEED != '0) else $error("p_seed_nonzero_r1: SEED must be nonzero");
  end

endmodule

// File: tb/test_xover_sel.sv
module test_xover_sel;

  localparam int unsigned P = 2;
  localparam logic [10:0] SEED_V = 11'h0A5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b1;
  logic       linkUp = 1'b0;
  logic [1:0] modeSel = 2'b11;
  logic       crossSel;
  logic       swapPulse;

  int checks = 0;
  int errors = 0;
  int ec = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xover_sel #(.TICK_DIV(P), .SEED(SEED_V)) i_xover_sel (
    .clk(clk), .rst_n(rst_n), .enable(enable), .linkUp(linkUp),
    .modeSel(modeSel), .crossSel(crossSel), .swapPulse(swapPulse)
  );

  function automatic logic [10:0] stepLfsr(input logic [10:0] s);
    return {s[9:0], s[10] ^ s[8]};
  endfunction

  function automatic logic [10:0] lfsrAt(input int n);
    logic [10:0] s = SEED_V;
    for (int k = 0; k < n; k++) s = stepLfsr(s);
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at edge %0d", req, act, exp, ec);
    end
  endtask

  // edge counter since reset release
  always @(posedge clk) if (rst_n) ec <= ec + 1;

  // reference model from the requirements
  logic [10:0] mLfsr;
  logic        mSel, mPulse, mArmed;
  int          mPre, mDwell;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mLfsr <= SEED_V; mSel <= 1'b0; mPulse <= 1'b0;
      mArmed <= 1'b0; mPre <= 0; mDwell <= 0;
    end else begin : step
      logic hunt, ex, nSel;
      hunt = modeSel[1] && enable && !linkUp;
      ex   = mArmed && (mPre == P - 1) && (mDwell == 1);
      if (modeSel == 2'b00) nSel = 1'b1;
      else if (modeSel == 2'b01) nSel = 1'b0;
      else if (hunt && ex) nSel = !mSel;
      else nSel = mSel;
      mPulse <= (nSel != mSel);
      mSel   <= nSel;
      if (!hunt) mArmed <= 1'b0;
      else if (!mArmed || ex) begin
        mArmed <= 1'b1; mDwell <= int'(mLfsr); mPre <= 0;
      end else if (mPre == P - 1) begin
        mPre <= 0; mDwell <= mDwell - 1;
      end else mPre <= mPre + 1;
      mLfsr <= stepLfsr(mLfsr);
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(crossSel == mSel, "R4 crossSel vs model", crossSel, mSel);
      check(swapPulse == mPulse, "R9 swapPulse vs model", swapPulse, mPulse);
    end
  end

  task automatic waitPulse(input int maxCyc, output bit found, output int at);
    found = 0; at = -1;
    for (int k = 0; k < maxCyc; k++) begin
      @(negedge clk);
      if (swapPulse) begin found = 1; at = ec; return; end
    end
  endtask

  task automatic countPulses(input int cyc, output int n);
    n = 0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (swapPulse) n++;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    bit found;
    int at, e1, exp, n;
    logic held;
    void'($urandom(32'd7741));

    // R1 reset state
    repeat (3) @(negedge clk);
    check(crossSel == 1'b0, "R1 reset crossSel", crossSel, 0);
    check(swapPulse == 1'b0, "R1 reset swapPulse", swapPulse, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(crossSel == 1'b0 && swapPulse == 1'b0, "R1 after release", crossSel, 0);

    // R5 exact first and second swap edges
    waitPulse(5000, found, at);
    exp = 1 + int'(SEED_V) * P;
    check(found && at == exp, "R5 first swap edge", at, exp);
    check(crossSel == 1'b1, "R4 first swap to MDIX", crossSel, 1);
    e1 = at;
    waitPulse(5000, found, at);
    exp = e1 + int'(lfsrAt(e1 - 1)) * P;
    check(found && at == exp, "R5 second swap edge", at, exp);

    // R2 forced modes
    modeSel = 2'b00;
    @(negedge clk);
    check(crossSel == 1'b1, "R2 forced MDIX", crossSel, 1);
    countPulses(5000, n);
    check(n == 0, "R2 timer stopped in forced MDIX", n, 0);
    modeSel = 2'b01;
    @(negedge clk);
    check(crossSel == 1'b0, "R2 forced MDI", crossSel, 0);
    check(swapPulse == 1'b1, "R9 pulse on forced change", swapPulse, 1);
    @(negedge clk);
    check(swapPulse == 1'b0, "R9 pulse one cycle", swapPulse, 0);

    // R3 value 10 hunts like automatic
    modeSel = 2'b10;
    waitPulse(5000, found, at);
    check(found, "R3 mode 10 hunts", found, 1);

    // R6 link freezes
    linkUp = 1'b1;
    @(negedge clk);
    held = crossSel;
    countPulses(6000, n);
    check(n == 0, "R6 no swap with link", n, 0);
    check(crossSel == held, "R6 mapping held", crossSel, held);

    // R7 link drop resumes with fresh interval from held mapping
    linkUp = 1'b0;
    e1 = ec + 1;
    waitPulse(5000, found, at);
    exp = e1 + int'(lfsrAt(e1 - 1)) * P;
    check(found && at == exp, "R7 resume swap edge", at, exp);
    check(crossSel == !held, "R7 swap from held mapping", crossSel, !held);

    // R8 enable low holds
    enable = 1'b0;
    @(negedge clk);
    held = crossSel;
    countPulses(6000, n);
    check(n == 0 && crossSel == held, "R8 enable low holds", n, 0);
    enable = 1'b1;

    // random segments checked by the model every cycle
    for (int s = 0; s < 40; s++) begin
      int r = $urandom_range(0, 9);
      modeSel = (r < 6) ? 2'b11 : (r == 6) ? 2'b10 : (r == 7) ? 2'b01 : 2'b00;
      linkUp  = ($urandom_range(0, 3) == 0);
      enable  = ($urandom_range(0, 5) != 0);
      repeat ($urandom_range(1, 2000)) @(negedge clk);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule